// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns a parallel character into an asynchronous serial frame. Software or a bus front end writes a character into a one-entry holding register. When the shift stage is idle, the character moves into it on the next clock. The line then carries a low start bit, the data bits least significant first, an optional parity bit, and a high stop period. Every bit period lasts a fixed number of pulses (16 by default) of a single-cycle baud enable. The baud enable is produced elsewhere.

The frame format comes from a set of line-control inputs:

- word length, 5 to 8 bits;
- parity on or off, with even, odd or stuck-at-level parity;
- one stop bit, or a long stop period, which is one and a half bits for 5-bit characters and two bits otherwise.

These inputs are sampled when a character enters the shift stage. A break input pulls the line low. A freeze input drops any frame in progress, keeps the line at the idle high level and blocks new loads. Two flags report the state of the block: one says the holding register is empty, the other says the whole transmitter is empty.

Top module: `sertx_tx_core`

## Requirements
- R1: After reset the serial line is 1, the holding-empty flag is 1 and the transmitter-empty flag is 1.
- R2: A write makes the holding-empty flag 0 from the next clock. If the shift stage is idle and freeze is low, the character moves into it on the following clock, and the holding-empty flag returns to 1 in that same cycle.
- R3: A frame starts with one 0 bit. It then sends the data bits least significant first, with the word-length field 00/01/10/11 selecting 5/6/7/8 bits. Data bits above the word length are never sent. Each bit lasts 16 baud-enable pulses.
- R4: With parity enabled and stick parity off, one parity bit follows the data. It makes the count of ones even when even-select is 1, and odd when even-select is 0.
- R5: With parity enabled and stick parity on, the parity bit is 0 when even-select is 1 and 1 when even-select is 0.
- R6: The stop period is high and lasts 16 pulses when stop-select is 0. When stop-select is 1 it lasts 32 pulses, or 24 pulses for 5-bit characters.
- R7: The transmitter-empty flag is 1 only when both the holding register and the shift stage are empty. It returns to 1 on the clock of the last pulse of the stop period.
- R8: If a character is waiting when a stop period ends, its start bit begins on that same clock, with no idle gap.
- R9: The framing inputs are sampled when a character enters the shift stage. Changing them during a frame does not alter that frame.
- R10: When break is 1 and freeze is 0, the serial line is 0. Break does not change either status flag.
- R11: While freeze is 1, the serial line is 1 even if break is 1, any frame in progress is abandoned, and no waiting character is loaded. A waiting character loads on the first clock after freeze falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle baud enable, OVS pulses per bit |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| wls | input | 2 | Word length: 00=5, 01=6, 10=7, 11=8 bits |
| stop_sel | input | 1 | Long stop period when 1 |
| par_en | input | 1 | Parity bit enable |
| even_sel | input | 1 | Even parity when 1, odd when 0 |
| stick_par | input | 1 | Force the parity bit to a fixed level |
| set_break | input | 1 | Force the line low |
| freeze | input | 1 | Abort, hold the line high, block loads |
| txd | output | 1 | Serial line |
| thr_empty | output | 1 | Holding register empty |
| tx_empty | output | 1 | Holding register and shift stage both empty |

## Verification
Results are due at different cycles, and each check samples on the falling edge at that point:

- **Write:** the holding-empty flag drops in the cycle after the write edge.
- **Load:** the load and the start bit appear one clock after that.
- **Bit boundaries:** every later boundary falls on the clock of a counted baud pulse. The bench counts pulses from the load edge and reads each bit after its eighth pulse, away from any boundary.
- **Stop period:** its length is checked exactly. The transmitter-empty flag is read as 0 one pulse before the expected end, and as 1 (or, for a waiting character, the line as 0) right after the final pulse.
- **Break and freeze:** in the default configuration they act on the line combinationally, so they are checked in the same cycle.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } tx_state_e;

   typedef struct packed {
      logic       stick;
      logic       even;
      logic       pen;
      logic       stop2;
      logic [1:0] wls;
   } frame_cfg_t;

   localparam int unsigned MIN_CHAR_BITS = 5;

endpackage

// File: rtl/sertx_hold_reg.sv
module sertx_hold_reg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic [DATA_W-1:0] data,
   output logic              empty
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data  <= '1;
         empty <= 1'b1;
      end else if (wr_en) begin
         data  <= wr_data;
         empty <= 1'b0;
      end else if (take) begin
         empty <= 1'b1;
      end
   end

endmodule

// File: rtl/sertx_parity_gen.sv
module sertx_parity_gen
   import sertx_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] data,
   input  logic [1:0]        wls,
   input  logic              even,
   input  logic              stick,
   output logic              par_bit
);

   logic [DATA_W-1:0] mask;

   // A data bit takes part when its index is below the word length.
   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      if (i < MIN_CHAR_BITS) begin : g_always
         assign mask[i] = 1'b1;
      end else begin : g_sel
         assign mask[i] = (32'(wls) >= (i - MIN_CHAR_BITS + 1));
      end
   end

   logic ones_odd;
   assign ones_odd = ^(data & mask);

   always_comb begin
      if (stick)     par_bit = ~even;
      else if (even) par_bit = ones_odd;
      else           par_bit = ~ones_odd;
   end

endmodule

// File: rtl/sertx_frame_seq.sv
module sertx_frame_seq
   import sertx_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              freeze,
   input  logic              hold_empty,
   input  logic [DATA_W-1:0] hold_data,
   input  logic [1:0]        wls_in,
   input  logic              stop2_in,
   input  logic              par_en_in,
   input  logic              par_in,
   output logic              take,
   output logic              frame_bit,
   output logic              busy
);

   localparam int unsigned CW = $clog2(2 * OVS + 1);
   localparam int unsigned IW = $clog2(DATA_W);
   localparam logic [CW-1:0] LEN_ONE  = CW'(OVS);
   localparam logic [CW-1:0] LEN_HALF = CW'(OVS + OVS / 2);
   localparam logic [CW-1:0] LEN_TWO  = CW'(2 * OVS);

   tx_state_e         state;
   logic [CW-1:0]     cnt;
   logic [IW-1:0]     idx;
   logic [DATA_W-1:0] shreg;
   logic [1:0]        wls_q;
   logic              stop2_q;
   logic              pen_q;
   logic              par_q;

   logic [CW-1:0] stop_len;
   logic [CW-1:0] seg_len;
   logic          seg_end;
   logic [IW-1:0] last_idx;

   always_comb begin
      if (!stop2_q)             stop_len = LEN_ONE;
      else if (wls_q == 2'b00)  stop_len = LEN_HALF;
      else                      stop_len = LEN_TWO;
   end

   assign seg_len  = (state == ST_STOP) ? stop_len : LEN_ONE;
   assign seg_end  = baud_tick && (state != ST_IDLE) && (cnt == seg_len - 1'b1);
   assign last_idx = IW'(MIN_CHAR_BITS - 1) + IW'(wls_q);
   assign take     = ((state == ST_IDLE) || ((state == ST_STOP) && seg_end))
                     && !hold_empty && !freeze;
   assign busy     = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         idx     <= '0;
         shreg   <= '1;
         wls_q   <= 2'b00;
         stop2_q <= 1'b0;
         pen_q   <= 1'b0;
         par_q   <= 1'b1;
      end else if (freeze) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else if (take) begin
         state   <= ST_START;
         cnt     <= '0;
         idx     <= '0;
         shreg   <= hold_data;
         wls_q   <= wls_in;
         stop2_q <= stop2_in;
         pen_q   <= par_en_in;
         par_q   <= par_in;
      end else if (seg_end) begin
         cnt <= '0;
         unique case (state)
            ST_START: state <= ST_DATA;
            ST_DATA: begin
               shreg <= {1'b1, shreg[DATA_W-1:1]};
               if (idx == last_idx) state <= pen_q ? ST_PAR : ST_STOP;
               else                 idx   <= idx + 1'b1;
            end
            ST_PAR:  state <= ST_STOP;
            default: state <= ST_IDLE;
         endcase
      end else if (baud_tick && busy) begin
         cnt <= cnt + 1'b1;
      end
   end

   always_comb begin
      unique case (state)
         ST_START: frame_bit = 1'b0;
         ST_DATA:  frame_bit = shreg[0];
         ST_PAR:   frame_bit = par_q;
         default:  frame_bit = 1'b1;
      endcase
   end

endmodule

// File: rtl/sertx_tx_core.sv
module sertx_tx_core
   import sertx_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned OVS     = 16,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        wls,
   input  logic              stop_sel,
   input  logic              par_en,
   input  logic              even_sel,
   input  logic              stick_par,
   input  logic              set_break,
   input  logic              freeze,
   output logic              txd,
   output logic              thr_empty,
   output logic              tx_empty
);

   if (DATA_W != MIN_CHAR_BITS + 3) begin : g_bad_width
      $error("DATA_W must cover the largest word length (8)");
   end
   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be even and at least 4");
   end

   frame_cfg_t        cfg_now;
   logic [DATA_W-1:0] hold_data;
   logic              hold_empty;
   logic              take;
   logic              par_bit;
   logic              frame_bit;
   logic              busy;
   logic              line_now;

   assign cfg_now = '{stick: stick_par, even: even_sel, pen: par_en,
                      stop2: stop_sel, wls: wls};

   sertx_hold_reg #(.DATA_W(DATA_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .take    (take),
      .data    (hold_data),
      .empty   (hold_empty)
   );

   sertx_parity_gen #(.DATA_W(DATA_W)) u_par (
      .data    (hold_data),
      .wls     (cfg_now.wls),
      .even    (cfg_now.even),
      .stick   (cfg_now.stick),
      .par_bit (par_bit)
   );

   sertx_frame_seq #(.DATA_W(DATA_W), .OVS(OVS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .baud_tick  (baud_tick),
      .freeze     (freeze),
      .hold_empty (hold_empty),
      .hold_data  (hold_data),
      .wls_in     (cfg_now.wls),
      .stop2_in   (cfg_now.stop2),
      .par_en_in  (cfg_now.pen),
      .par_in     (par_bit),
      .take       (take),
      .frame_bit  (frame_bit),
      .busy       (busy)
   );

   // Freeze outranks break; break outranks the frame.
   assign line_now = freeze ? 1'b1 : (set_break ? 1'b0 : frame_bit);

   if (REG_OUT) begin : g_reg_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) txd <= 1'b1;
         else        txd <= line_now;
      end
   end else begin : g_comb_line
      assign txd = line_now;
   end

   assign thr_empty = hold_empty;
   assign tx_empty  = hold_empty && !busy;

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic set_break,
   input logic freeze,
   input logic txd,
   input logic thr_empty,
   input logic tx_empty
);

   // R2
   write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !thr_empty);

   // R2
   load_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(thr_empty) |-> !tx_empty);

   // R7
   empty_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> thr_empty);

   // R10
   break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_break && !freeze && $past(set_break) && !$past(freeze)) |-> !txd);

   // R11
   freeze_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && $past(freeze)) |-> (txd && !$rose(thr_empty)));

endmodule

bind sertx_tx_core sertx_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .set_break (set_break),
   .freeze    (freeze),
   .txd       (txd),
   .thr_empty (thr_empty),
   .tx_empty  (tx_empty)
);

// File: tb/tb_sertx_tx_core.sv
`timescale 1ns/1ps
module tb_sertx_tx_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [1:0] wls = 2'b11;
   logic       stop_sel = 1'b0;
   logic       par_en = 1'b0;
   logic       even_sel = 1'b0;
   logic       stick_par = 1'b0;
   logic       set_break = 1'b0;
   logic       freeze = 1'b0;
   logic       txd, thr_empty, tx_empty;
   logic [1:0] div = 2'd0;
   int         n_chk = 0;
   int         n_err = 0;

   always #5 clk = ~clk;

   sertx_tx_core dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
      .wr_data(wr_data), .wls(wls), .stop_sel(stop_sel), .par_en(par_en),
      .even_sel(even_sel), .stick_par(stick_par), .set_break(set_break),
      .freeze(freeze), .txd(txd), .thr_empty(thr_empty), .tx_empty(tx_empty)
   );

   // One baud pulse every four clocks, changed on the falling edge.
   always @(negedge clk) begin
      if (!rst_n) begin
         div       <= 2'd0;
         baud_tick <= 1'b0;
      end else begin
         div       <= div + 2'd1;
         baud_tick <= (div == 2'd3);
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // cfg: [1:0] word length, [2] long stop, [3] parity on, [4] even, [5] stick
   task automatic apply_cfg(input logic [6:0] c);
      wls = c[1:0]; stop_sel = c[2]; par_en = c[3];
      even_sel = c[4]; stick_par = c[5];
   endtask

   function automatic int frame_ticks(input logic [6:0] c);
      int st;
      st = !c[2] ? 16 : ((c[1:0] == 2'b00) ? 24 : 32);
      return 16 * (1 + 5 + int'(c[1:0]) + int'(c[3])) + st;
   endfunction

   function automatic logic exp_par(input logic [7:0] d, input logic [6:0] c);
      logic p;
      p = 1'b0;
      for (int i = 0; i < 5 + int'(c[1:0]); i++) p ^= d[i];
      if (c[5]) return ~c[4];
      return c[4] ? p : ~p;
   endfunction

   // Waits for n baud pulses, then moves to the falling edge.
   task automatic tick_wait(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         while (!baud_tick) @(posedge clk);
      end
      @(negedge clk);
   endtask

   // Starts and ends on a falling edge; the shift stage must be idle.
   task automatic send_char(input logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R2 holding full after write", thr_empty, 1'b0);
      chk("R7 not empty with holding full", tx_empty, 1'b0);
      @(negedge clk);
      chk("R2 holding empty after load", thr_empty, 1'b1);
      chk("R3 start bit begins", txd, 1'b0);
   endtask

   // Called on the falling edge just after the load edge.
   task automatic check_frame(input logic [7:0] d, input logic [6:0] c, input bit has_next,
                              input logic [7:0] nd, input logic [6:0] nc, input string ctx);
      int nb, cnt, tot;
      nb  = 5 + int'(c[1:0]);
      tot = frame_ticks(c);
      tick_wait(8); cnt = 8;
      chk({"R3 start mid ", ctx}, txd, 1'b0);
      if (has_next) begin
         wr_en = 1'b1; wr_data = nd; apply_cfg(nc);
         @(negedge clk);
         wr_en = 1'b0;
         chk({"R2 queued write ", ctx}, thr_empty, 1'b0);
      end
      for (int i = 0; i < nb; i++) begin
         tick_wait(16); cnt += 16;
         chk({"R3 data bit ", ctx}, txd, d[i]);
      end
      if (c[3]) begin
         tick_wait(16); cnt += 16;
         chk(c[5] ? {"R5 stick parity ", ctx} : {"R4 parity ", ctx}, txd, exp_par(d, c));
      end
      tick_wait(16); cnt += 16;
      chk({"R6 stop level ", ctx}, txd, 1'b1);
      tick_wait(tot - 1 - cnt);
      chk({"R6 still in stop ", ctx}, tx_empty, 1'b0);
      chk({"R6 stop high at end ", ctx}, txd, 1'b1);
      tick_wait(1);
      if (has_next) begin
         chk({"R8 next start at once ", ctx}, txd, 1'b0);
         chk({"R8 holding drained ", ctx}, thr_empty, 1'b1);
      end else begin
         chk({"R7 empty after stop ", ctx}, tx_empty, 1'b1);
         chk({"R6 idle line ", ctx}, txd, 1'b1);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (5) @(negedge clk);
      // R1
      chk("R1 line idle in reset", txd, 1'b1);
      chk("R1 holding empty in reset", thr_empty, 1'b1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 line idle after reset", txd, 1'b1);
      chk("R1 transmitter empty after reset", tx_empty, 1'b1);

      // Directed formats: 8N1, 7E1, 6O2, 5-bit long stop, stick parity both ways
      apply_cfg(7'h03); send_char(8'hA5); check_frame(8'hA5, 7'h03, 0, 0, 0, "8N1");
      apply_cfg(7'h1A); send_char(8'h3C); check_frame(8'h3C, 7'h1A, 0, 0, 0, "7E1");
      apply_cfg(7'h0D); send_char(8'h2B); check_frame(8'h2B, 7'h0D, 0, 0, 0, "6O2");
      apply_cfg(7'h04); send_char(8'hF3); check_frame(8'hF3, 7'h04, 0, 0, 0, "5N1.5");
      apply_cfg(7'h3B); send_char(8'h81); check_frame(8'h81, 7'h3B, 0, 0, 0, "stick even");
      apply_cfg(7'h2F); send_char(8'h7E); check_frame(8'h7E, 7'h2F, 0, 0, 0, "stick odd");

      // R9: config changed mid-frame applies only to the next character
      apply_cfg(7'h1B); send_char(8'h96);
      check_frame(8'h96, 7'h1B, 1, 8'h55, 7'h04, "R9 first");
      check_frame(8'h55, 7'h04, 0, 0, 0, "R9 second");

      // R10: break while idle
      set_break = 1'b1;
      @(negedge clk);
      chk("R10 break drives line low", txd, 1'b0);
      chk("R10 break keeps flags", tx_empty, 1'b1);
      set_break = 1'b0;
      @(negedge clk);
      chk("R10 line back high", txd, 1'b1);

      // R11: freeze aborts a frame and holds off a waiting character
      apply_cfg(7'h03); send_char(8'h00);
      tick_wait(20);
      freeze = 1'b1;
      @(negedge clk);
      chk("R11 line marking", txd, 1'b1);
      chk("R11 frame abandoned", tx_empty, 1'b1);
      wr_en = 1'b1; wr_data = 8'hC9;
      @(negedge clk);
      wr_en = 1'b0;
      repeat (50) @(negedge clk);
      chk("R11 no load while frozen", thr_empty, 1'b0);
      set_break = 1'b1;
      @(negedge clk);
      chk("R11 freeze outranks break", txd, 1'b1);
      set_break = 1'b0;
      freeze = 1'b0;
      @(negedge clk);
      chk("R11 load after release", thr_empty, 1'b1);
      chk("R11 start after release", txd, 1'b0);
      check_frame(8'hC9, 7'h03, 0, 0, 0, "R11 resumed");

      // Random single frames
      for (int k = 0; k < 16; k++) begin
         logic [6:0] c;
         logic [7:0] d;
         c = 7'($urandom) & 7'h3F;
         d = 8'($urandom);
         apply_cfg(c); send_char(d);
         check_frame(d, c, 0, 0, 0, "random");
      end

      // Random back-to-back pairs
      for (int k = 0; k < 6; k++) begin
         logic [6:0] ca, cb;
         logic [7:0] da, db;
         ca = 7'($urandom) & 7'h3F; cb = 7'($urandom) & 7'h3F;
         da = 8'($urandom);         db = 8'($urandom);
         apply_cfg(ca); send_char(da);
         check_frame(da, ca, 1, db, cb, "R8 pair first");
         check_frame(db, cb, 0, 0, 0, "R8 pair second");
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule